// File: doc/BRIEF.md
# Chaining IV Context Register Guard

This block keeps the 128-bit chaining initialization vector used by a block-cipher chaining mode and polices host access to it. The host sees the vector as two 64-bit halves chosen by a select bit. Half 0 holds the low 64 bits, which are bytes 1 to 8. Half 1 holds the high 64 bits, which are bytes 9 to 16. A write is taken only while the chaining mode is enabled and no message is in flight. A read returns data only once the engine has signalled that the message is done.

A write that breaks these rules raises a sticky context error and leaves the vector untouched. A read that breaks them raises a sticky early-read error and returns zero. While a message runs, each finished block loads the engine's new chaining value into the register. A save taken after done therefore captures the latest value, and writing that value back later resumes an interrupted message.

The done status bit is set by the engine's done pulse and cleared when the next message starts. Both error flags stay set until a clear strobe or reset.

Top module: `ivctx_guard`

## Requirements
- R1: With `host_sel` = 0 the host accesses `iv_out[63:0]`. With `host_sel` = 1 it accesses `iv_out[127:64]`.
- R2: A write with `cbc_en` = 1 and `busy` = 0 stores `host_wdata` into the selected half, visible on `iv_out` one cycle later.
- R3: A write while `busy` = 1 or while `cbc_en` = 0 sets `ctx_err` one cycle later.
- R4: A rejected write leaves `iv_out` unchanged.
- R5: A read while `done_stat` = 1 puts the selected half on `host_rdata` one cycle later and raises no error. `host_rdata` holds its value until the next read.
- R6: A read while `done_stat` = 0 sets `early_err` and drives `host_rdata` to zero, both one cycle later.
- R7: `ctx_err` and `early_err` stay set until `err_clr` clears them one cycle later. An error raised in the same cycle as `err_clr` keeps its flag set.
- R8: `blk_done` while `busy` = 1 loads `chain_in` into the whole vector one cycle later. `blk_done` while `busy` = 0 has no effect.
- R9: `msg_done` sets `done_stat` and `msg_start` clears it, each one cycle later. When both arrive in the same cycle, `msg_start` wins.
- R10: Synchronous reset zeroes the vector, `host_rdata`, `done_stat` and both error flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_sel | input | 1 | Half select: 0 low, 1 high |
| host_wdata | input | 64 | Host write data |
| cbc_en | input | 1 | Chaining mode enabled |
| msg_start | input | 1 | New message starts (pulse) |
| busy | input | 1 | Message in flight |
| blk_done | input | 1 | One block finished (pulse) |
| chain_in | input | 128 | New chaining value from the engine |
| msg_done | input | 1 | Message finished (pulse) |
| err_clr | input | 1 | Clear both error flags (pulse) |
| iv_out | output | 128 | Stored vector |
| host_rdata | output | 64 | Registered read data |
| done_stat | output | 1 | Done status bit |
| ctx_err | output | 1 | Sticky context error |
| early_err | output | 1 | Sticky early-read error |

## Verification
A wrong acceptance decision shows on the cycle after the offending strobe. A rejected write that slips through changes `iv_out`. A legal write flagged as illegal raises `ctx_err` with no change to the vector. A wrong done status shows first as a mismatch on the next read, because `host_rdata` is zero and `early_err` rises when data was expected, or the reverse. A stale or wrong chaining load shows on `iv_out` one cycle after `blk_done`, and it shows again in every later save.

// File: rtl/ivg_pkg.sv
package ivg_pkg;

    parameter int HALF_W = 64;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_sel_e;

    typedef struct packed {
        logic ctx;
        logic early;
    } err_flags_t;

endpackage

// File: rtl/ivctx_store.sv
module ivctx_store #(
    parameter int HALF_W = ivg_pkg::HALF_W,
    localparam int IV_W  = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ok,
    input  logic              wr_sel,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              chain_ld,
    input  logic [IV_W-1:0]   chain_in,
    output logic [IV_W-1:0]   iv_q
);

    for (genvar h = 0; h < 2; h++) begin : g_half
        always_ff @(posedge clk) begin
            if (rst) begin
                iv_q[h*HALF_W +: HALF_W] <= '0;
            end else if (chain_ld) begin
                iv_q[h*HALF_W +: HALF_W] <= chain_in[h*HALF_W +: HALF_W];
            end else if (wr_ok && (wr_sel == 1'(h))) begin
                iv_q[h*HALF_W +: HALF_W] <= wr_data;
            end
        end
    end

    AST_CHAIN_LOAD: assert property (@(posedge clk) disable iff (rst)
        chain_ld |=> iv_q == $past(chain_in)); // R8

endmodule

// File: rtl/ivctx_police.sv
module ivctx_police #(
    parameter int HALF_W = ivg_pkg::HALF_W,
    localparam int IV_W  = 2 * HALF_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic                re,
    input  logic                sel,
    input  logic                cbc_en,
    input  logic                busy,
    input  logic                done_stat,
    input  logic                err_clr,
    input  logic [IV_W-1:0]     iv_q,
    output logic                wr_ok,
    output logic [HALF_W-1:0]   rdata,
    output ivg_pkg::err_flags_t flags
);
    import ivg_pkg::*;

    logic rd_ok;
    logic wr_bad;
    logic rd_bad;

    always_comb begin
        wr_ok  = we && cbc_en && !busy;
        wr_bad = we && !wr_ok;
        rd_ok  = re && done_stat;
        rd_bad = re && !done_stat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            if (!rd_ok) begin
                rdata <= '0;
            end else if (half_sel_e'(sel) == HALF_HI) begin
                rdata <= iv_q[IV_W-1:HALF_W];
            end else begin
                rdata <= iv_q[HALF_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags <= '0;
        end else begin
            flags.ctx   <= (flags.ctx   && !err_clr) || wr_bad;
            flags.early <= (flags.early && !err_clr) || rd_bad;
        end
    end

    AST_CTX_ERR_RAISE: assert property (@(posedge clk) disable iff (rst)
        (we && (busy || !cbc_en)) |=> flags.ctx); // R3

    AST_EARLY_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (re && !done_stat) |=> (flags.early && rdata == '0)); // R6

    AST_CTX_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags.ctx && !err_clr) |=> flags.ctx); // R7

    AST_EARLY_STICKY: assert property (@(posedge clk) disable iff (rst)
        (flags.early && !err_clr) |=> flags.early); // R7

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !re |=> $stable(rdata)); // R5

endmodule

// File: rtl/ivctx_status.sv
module ivctx_status (
    input  logic clk,
    input  logic rst,
    input  logic msg_start,
    input  logic msg_done,
    output logic done_stat
);

    always_ff @(posedge clk) begin
        if (rst) begin
            done_stat <= 1'b0;
        end else if (msg_start) begin
            done_stat <= 1'b0;
        end else if (msg_done) begin
            done_stat <= 1'b1;
        end
    end

    AST_DONE_CLEAR_ON_START: assert property (@(posedge clk) disable iff (rst)
        msg_start |=> !done_stat); // R9

    AST_DONE_SET: assert property (@(posedge clk) disable iff (rst)
        (msg_done && !msg_start) |=> done_stat); // R9

endmodule

// File: rtl/ivctx_guard.sv
module ivctx_guard #(
    parameter int HALF_W = ivg_pkg::HALF_W,
    localparam int IV_W  = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic              host_re,
    input  logic              host_sel,
    input  logic [HALF_W-1:0] host_wdata,
    input  logic              cbc_en,
    input  logic              msg_start,
    input  logic              busy,
    input  logic              blk_done,
    input  logic [IV_W-1:0]   chain_in,
    input  logic              msg_done,
    input  logic              err_clr,
    output logic [IV_W-1:0]   iv_out,
    output logic [HALF_W-1:0] host_rdata,
    output logic              done_stat,
    output logic              ctx_err,
    output logic              early_err
);
    import ivg_pkg::*;

    logic       wr_ok;
    logic       chain_ld;
    err_flags_t flags;

    assign chain_ld = blk_done && busy;

    ivctx_status status_i (
        .clk       (clk),
        .rst       (rst),
        .msg_start (msg_start),
        .msg_done  (msg_done),
        .done_stat (done_stat)
    );

    ivctx_police #(.HALF_W(HALF_W)) police_i (
        .clk       (clk),
        .rst       (rst),
        .we        (host_we),
        .re        (host_re),
        .sel       (host_sel),
        .cbc_en    (cbc_en),
        .busy      (busy),
        .done_stat (done_stat),
        .err_clr   (err_clr),
        .iv_q      (iv_out),
        .wr_ok     (wr_ok),
        .rdata     (host_rdata),
        .flags     (flags)
    );

    ivctx_store #(.HALF_W(HALF_W)) store_i (
        .clk      (clk),
        .rst      (rst),
        .wr_ok    (wr_ok),
        .wr_sel   (host_sel),
        .wr_data  (host_wdata),
        .chain_ld (chain_ld),
        .chain_in (chain_in),
        .iv_q     (iv_out)
    );

    assign ctx_err   = flags.ctx;
    assign early_err = flags.early;

    AST_REJECT_KEEPS_IV: assert property (@(posedge clk) disable iff (rst)
        (host_we && (busy || !cbc_en) && !(blk_done && busy)) |=> $stable(iv_out)); // R4

    AST_IDLE_BLK_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (blk_done && !busy && !host_we) |=> $stable(iv_out)); // R8

endmodule

// File: tb/ivctx_guard_tb_top.sv
module ivctx_guard_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic         host_we, host_re, host_sel;
    logic [63:0]  host_wdata;
    logic         cbc_en, msg_start, busy, blk_done, msg_done, err_clr;
    logic [127:0] chain_in;
    logic [127:0] iv_out;
    logic [63:0]  host_rdata;
    logic         done_stat, ctx_err, early_err;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    ivctx_guard dut_i (.*);

    typedef struct packed {
        logic we, re, sel;
        logic [63:0] wd;
        logic cbc, bsy, start, mdone, clr, blk;
        logic e_ctx, e_early, e_done;
        logic [63:0] e_rd;
        logic [3:0] req;
    } vec_t;

    localparam logic [63:0] VA = 64'h1111_2222_3333_4444;
    localparam logic [63:0] VB = 64'h5555_6666_7777_8888;
    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{1,0,0,VA,1,0,0,0,0,0, 0,0,0,64'h0, 2},  // R2 low write
        '{1,0,1,VB,1,0,0,0,0,0, 0,0,0,64'h0, 2},  // R2 high write
        '{0,1,0,64'h0,1,0,0,0,0,0, 0,1,0,64'h0, 6},  // R6 early read
        '{0,0,0,64'h0,1,0,0,0,1,0, 0,0,0,64'h0, 7},  // R7 clear
        '{0,0,0,64'h0,1,0,0,1,0,0, 0,0,1,64'h0, 9},  // R9 done set
        '{0,1,0,64'h0,1,0,0,0,0,0, 0,0,1,VA, 5},  // R5 read low
        '{0,1,1,64'h0,1,0,0,0,0,0, 0,0,1,VB, 1},  // R1 read high
        '{1,0,0,64'hDEAD,0,0,0,0,0,0, 1,0,1,VB, 3},  // R3 cbc off
        '{1,0,0,64'hBEEF,1,1,0,0,1,0, 1,0,1,VB, 7},  // R7 clear loses to new error
        '{0,0,0,64'h0,1,0,0,0,1,0, 0,0,1,VB, 7},  // R7 clear
        '{0,0,0,64'h0,1,0,1,1,0,0, 0,0,0,VB, 9},  // R9 start wins
        '{0,0,0,64'h0,1,0,0,1,0,0, 0,0,1,VB, 9},  // R9 done set
        '{0,0,0,64'h0,1,0,1,0,0,0, 0,0,0,VB, 9}   // R9 start clears
    };

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic [127:0] chn);
        @(negedge clk);
        host_we = v.we; host_re = v.re; host_sel = v.sel; host_wdata = v.wd;
        cbc_en = v.cbc; busy = v.bsy; msg_start = v.start; msg_done = v.mdone;
        err_clr = v.clr; blk_done = v.blk; chain_in = chn;
        @(negedge clk);
    endtask

    task automatic report;
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=hung expected=done");
        report();
    end

    initial begin
        vec_t idle;
        idle = '{0,0,0,64'h0,1,0,0,0,0,0, 0,0,0,64'h0, 0};
        rst = 1'b1;
        host_we = 0; host_re = 0; host_sel = 0; host_wdata = '0; cbc_en = 0;
        msg_start = 0; busy = 0; blk_done = 0; msg_done = 0; err_clr = 0; chain_in = '0;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 iv", iv_out, '0);
        chk("R10 flags", {host_rdata, done_stat, ctx_err, early_err}, '0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i], '0);
            chk($sformatf("R%0d row%0d ctx", TBL[i].req, i), ctx_err, TBL[i].e_ctx);
            chk($sformatf("R%0d row%0d early", TBL[i].req, i), early_err, TBL[i].e_early);
            chk($sformatf("R%0d row%0d done", TBL[i].req, i), done_stat, TBL[i].e_done);
            chk($sformatf("R%0d row%0d rdata", TBL[i].req, i), host_rdata, TBL[i].e_rd);
        end

        // R4 rejected writes (rows 7 and 8) left the vector as written; R1 half mapping
        chk("R4 iv after rejects", iv_out, {VB, VA});
        chk("R1 low half", iv_out[63:0], VA);

        // R2 accepted write visible on iv_out
        drive('{1,0,0,64'hCAFE_0000_0000_0001,1,0,0,0,0,0, 0,0,0,64'h0, 2}, '0);
        chk("R2 write low", iv_out, {VB, 64'hCAFE_0000_0000_0001});

        // R8 chaining load while busy
        drive('{0,0,0,64'h0,1,1,0,0,0,1, 0,0,0,64'h0, 8}, {64'hA5A5, 64'h5A5A});
        chk("R8 chain load", iv_out, {64'hA5A5, 64'h5A5A});

        // R8 blk_done ignored when not busy
        drive('{0,0,0,64'h0,1,0,0,0,0,1, 0,0,0,64'h0, 8}, {128{1'b1}});
        chk("R8 idle blk ignored", iv_out, {64'hA5A5, 64'h5A5A});

        // R3 write while busy; R4 vector kept
        drive('{1,0,1,64'h1234,1,1,0,0,0,0, 0,0,0,64'h0, 3}, '0);
        chk("R3 busy write err", ctx_err, 1'b1);
        chk("R4 busy write kept", iv_out, {64'hA5A5, 64'h5A5A});

        // R5 save after done captures chained value
        drive('{0,0,0,64'h0,1,0,0,1,1,0, 0,0,0,64'h0, 9}, '0);
        drive('{0,1,1,64'h0,1,0,0,0,0,0, 0,0,0,64'h0, 5}, '0);
        chk("R5 save high", host_rdata, 64'hA5A5);
        chk("R5 no early err", early_err, 1'b0);
        drive(idle, '0);
        chk("R5 rdata hold", host_rdata, 64'hA5A5);

        // R10 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        chk("R10 reset iv", iv_out, '0);
        chk("R10 reset status", {host_rdata, done_stat, ctx_err, early_err}, '0);
        rst = 1'b0;

        report();
    end

endmodule